// File: doc/BRIEF.md
# Grouped Level Interrupt Combiner

This block gathers a wide vector of level-sensitive interrupt sources and folds them into one upstream line per group of eight. Each source has an enable bit. A group's output is high when at least one of its sources is both asserted and enabled. The output is taken from a register, so it follows the sources one clock later. Every source is treated as a level. There is no edge capture and no trigger-mode setting.

Software reaches the enables through a small synchronous register port. Four groups share one 32-bit word, one byte lane each. A register set covering four groups repeats every 0x10 bytes:

| Offset | Access | Behaviour |
|--------|--------|-----------|
| +0x0 | write | Each 1 bit sets the matching enable. |
| +0x4 | write | Each 1 bit clears the matching enable. |
| +0x0 or +0x4 | read | Returns the current enable bits. |
| +0xC | read | Returns the masked pending bits. |

A separate lookup port names a group and returns, one cycle later, the code of the lowest-numbered pending source in that group. If nothing is pending, it returns an all-ones code.

Top module: `irq_merge_bank`

## Requirements
- R1: Source n belongs to group n/8 at bit n%8. grp_irq_o[g] is the OR of (source AND enable) over the eight sources of group g, sampled in a register, so it reflects the inputs of the previous clock edge.
- R2: The register set at byte address k*0x10 serves groups 4k to 4k+3. Group g occupies bits [(g%4)*8+7:(g%4)*8] of each word in that set. Address bits [3:2] select the register within the set.
- R3: A write to set offset +0x0 sets each enable whose data bit is 1. Data bits that are 0 leave their enables unchanged.
- R4: A write to set offset +0x4 clears each enable whose data bit is 1, and 0 bits change nothing. Writing 0xFF to one byte lane clears all eight enables of that group and leaves the other lanes unchanged.
- R5: A read of offset +0x0 or +0x4 returns the current enable bits. Read data is registered: bus_rdata shows the word for the address presented on the previous clock edge.
- R6: A read of offset +0xC returns source AND enable in each lane. Writes to +0x8 and +0xC change no enable, and a read of +0x8 returns zero.
- R7: Byte lanes of groups at or beyond NUM_GROUPS, and whole register sets beyond the last group, read as zero and ignore writes.
- R8: One cycle after pick_grp_i is presented, pick_code_o equals g*8+b, where b is the lowest bit of (source AND enable) in group g. When that group has nothing pending, or g >= NUM_GROUPS, pick_code_o is all ones (CODE_W bits).
- R9: After reset all enables are zero, grp_irq_o and bus_rdata are zero and pick_code_o is all ones.
- R10: A group output holds no memory of past activity. When its sources fall or their enables are cleared, the output drops on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_GROUPS*8 | Level interrupt sources |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| grp_irq_o | output | NUM_GROUPS | Combined output of each group |
| pick_grp_i | input | GRP_W | Group to search for the lowest pending source |
| pick_code_o | output | CODE_W | Lowest pending source code, or all ones |

## Verification
The bench builds the combiner with six groups and a 6-bit address. The second register set then holds two real groups and two absent lanes, and a third set lies wholly outside the populated range. Both kinds of dead address can be probed directly. With only 48 sources, every source can be walked singly. Each group can then be swept through all 256 input patterns against a mixed enable pattern, while the other groups are held high. This checks the lowest-source picker and the output isolation between groups exhaustively.

// File: rtl/irq_merge_bank.sv
module irq_merge_bank #(
  parameter int NUM_GROUPS = 16,
  parameter int ADDR_W     = 8,
  parameter int GRP_W      = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  parameter int CODE_W     = $clog2(NUM_GROUPS * 8) + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_GROUPS*8-1:0] src_i,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic                    bus_we,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  output logic [NUM_GROUPS-1:0]   grp_irq_o,
  input  logic [GRP_W-1:0]        pick_grp_i,
  output logic [CODE_W-1:0]       pick_code_o
);

  localparam int NUM_SRC  = NUM_GROUPS * 8;
  localparam int NUM_SETS = (NUM_GROUPS + 3) / 4;
  localparam int SET_W    = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1;
  localparam logic [CODE_W-1:0] NO_PEND = '1;

  logic [NUM_SRC-1:0]    en_q, en_d, act;
  logic [7:0]            grp_act [NUM_GROUPS];
  logic [NUM_GROUPS-1:0] grp_any;
  logic [31:0]           en_word  [NUM_SETS];
  logic [31:0]           act_word [NUM_SETS];

  logic [31:0]      set_idx;
  logic [1:0]       reg_sel;
  logic [SET_W-1:0] word_sel;
  logic             hit, wr_set, wr_clr;

  assign set_idx  = 32'(bus_addr[ADDR_W-1:4]);
  assign reg_sel  = bus_addr[3:2];
  assign word_sel = set_idx[SET_W-1:0];
  assign hit      = set_idx < NUM_SETS;
  assign wr_set   = bus_we && hit && (reg_sel == 2'd0);
  assign wr_clr   = bus_we && hit && (reg_sel == 2'd1);
  assign act      = src_i & en_q;

  for (genvar b = 0; b < NUM_SRC; b++) begin : g_en
    localparam int SB = b / 32;
    localparam int LB = b % 32;
    logic sel;
    assign sel     = (set_idx == SB) && bus_wdata[LB];
    assign en_d[b] = !sel  ? en_q[b] :
                     wr_set ? 1'b1    :
                     wr_clr ? 1'b0    : en_q[b];
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    assign grp_act[g] = act[g*8 +: 8];
    assign grp_any[g] = |grp_act[g];
  end

  for (genvar k = 0; k < NUM_SETS; k++) begin : g_set
    for (genvar l = 0; l < 4; l++) begin : g_lane
      localparam int G = 4 * k + l;
      if (G < NUM_GROUPS) begin : g_live
        assign en_word[k][l*8 +: 8]  = en_q[G*8 +: 8];
        assign act_word[k][l*8 +: 8] = act[G*8 +: 8];
      end else begin : g_dead
        assign en_word[k][l*8 +: 8]  = 8'h00;
        assign act_word[k][l*8 +: 8] = 8'h00;
      end
    end
  end

  logic [31:0] rd_next;
  always_comb begin
    rd_next = 32'h0;
    if (hit) begin
      case (reg_sel)
        2'd0, 2'd1: rd_next = en_word[word_sel];
        2'd3:       rd_next = act_word[word_sel];
        default:    rd_next = 32'h0;
      endcase
    end
  end

  logic             pick_hit;
  logic [7:0]       pick_vec;
  logic [2:0]       low_bit;
  logic [CODE_W-1:0] pick_next;

  assign pick_hit = 32'(pick_grp_i) < NUM_GROUPS;
  assign pick_vec = pick_hit ? grp_act[pick_grp_i] : 8'h00;

  always_comb begin
    low_bit = 3'd0;
    for (int i = 7; i >= 0; i--)
      if (pick_vec[i]) low_bit = 3'(i);
  end

  assign pick_next = (pick_vec == 8'h00) ? NO_PEND : CODE_W'({pick_grp_i, low_bit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q        <= '0;
      grp_irq_o   <= '0;
      bus_rdata   <= 32'h0;
      pick_code_o <= NO_PEND;
    end else begin
      en_q        <= en_d;
      grp_irq_o   <= grp_any;
      bus_rdata   <= rd_next;
      pick_code_o <= pick_next;
    end
  end

endmodule

module irq_merge_bank_chk #(
  parameter int NUM_GROUPS = 16,
  parameter int ADDR_W     = 8,
  parameter int GRP_W      = 4,
  parameter int CODE_W     = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NUM_GROUPS*8-1:0] src_i,
  input logic [ADDR_W-1:0]       bus_addr,
  input logic [31:0]             bus_rdata,
  input logic [NUM_GROUPS-1:0]   grp_irq_o,
  input logic [GRP_W-1:0]        pick_grp_i,
  input logic [CODE_W-1:0]       pick_code_o
);
  localparam int NUM_SETS = (NUM_GROUPS + 3) / 4;
  localparam logic [CODE_W-1:0] NO_PEND = '1;

  logic [NUM_GROUPS-1:0] src_any;
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_any
    assign src_any[g] = |src_i[g*8 +: 8];
  end

  a_r1_irq_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((grp_irq_o & ~$past(src_any)) == '0));

  a_r8_pick_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_code_o == NO_PEND) || (32'(pick_code_o) < NUM_GROUPS * 8));

  a_r8_pick_own_group: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pick_code_o == NO_PEND) || (32'(pick_code_o >> 3) == 32'($past(pick_grp_i)))));

  a_r7_dead_set_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(bus_addr >> 4) >= NUM_SETS) |=> (bus_rdata == 32'h0));

  a_r6_gap_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[3:2] == 2'b10) |=> (bus_rdata == 32'h0));
endmodule

bind irq_merge_bank irq_merge_bank_chk #(
  .NUM_GROUPS(NUM_GROUPS), .ADDR_W(ADDR_W), .GRP_W(GRP_W), .CODE_W(CODE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .grp_irq_o(grp_irq_o),
  .pick_grp_i(pick_grp_i), .pick_code_o(pick_code_o)
);

// File: tb/irq_merge_bank_bench.sv
`timescale 1ns/1ps
module irq_merge_bank_bench;
  localparam int NG = 6;
  localparam int AW = 6;
  localparam int NS = NG * 8;
  localparam int GW = 3;
  localparam int CW = 7;
  localparam int NOP = 127;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NS-1:0] src;
  logic [AW-1:0] addr;
  logic          we;
  logic [31:0]   wdata;
  logic [31:0]   rdata;
  logic [NG-1:0] irq;
  logic [GW-1:0] pgrp;
  logic [CW-1:0] pcode;

  always #2.5 clk = ~clk;

  irq_merge_bank #(.NUM_GROUPS(NG), .ADDR_W(AW)) u_irq_merge_bank (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_addr(addr), .bus_we(we),
    .bus_wdata(wdata), .bus_rdata(rdata), .grp_irq_o(irq),
    .pick_grp_i(pgrp), .pick_code_o(pcode)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [NS-1:0] m_en;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word_of(input logic [NS-1:0] v, input int k);
    logic [31:0] w = 32'h0;
    for (int b = 0; b < 32; b++)
      if (k * 32 + b < NS) w[b] = v[k * 32 + b];
    return w;
  endfunction

  function automatic logic [31:0] irq_of();
    logic [31:0] r = 32'h0;
    logic [NS-1:0] a = src & m_en;
    for (int g = 0; g < NG; g++) r[g] = |a[g*8 +: 8];
    return r;
  endfunction

  function automatic int pick_of(input int g);
    logic [NS-1:0] a = src & m_en;
    if (g >= NG) return NOP;
    for (int i = 0; i < 8; i++) if (a[g*8 + i]) return g * 8 + i;
    return NOP;
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    if (32'(a >> 4) * 4 < NG) begin
      for (int b = 0; b < 32; b++) begin
        int idx = 32'(a >> 4) * 32 + b;
        if (idx < NS && d[b]) begin
          if (a[3:2] == 2'd0) m_en[idx] = 1'b1;
          if (a[3:2] == 2'd1) m_en[idx] = 1'b0;
        end
      end
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] r);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    r = rdata;
  endtask

  task automatic check_enables(input string req);
    logic [31:0] r;
    for (int k = 0; k < 2; k++) begin
      rd(AW'(k * 16), r);     check(req, r, word_of(m_en, k));
      rd(AW'(k * 16 + 4), r); check(req, r, word_of(m_en, k));
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; src = '0; addr = '0; we = 1'b0; wdata = '0; pgrp = '0; m_en = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check("R9 rdata", rdata, 32'h0);
    check("R9 irq", 32'(irq), 32'h0);
    check("R9 pick", 32'(pcode), NOP);
    check_enables("R9 enables");

    // R3 set, zero bits inert; R2 lane placement
    wr(6'h00, 32'hA5C3_0F96);
    wr(6'h10, 32'h1234_8001);
    check_enables("R3 set");
    check("R2 set1 lanes", word_of(m_en, 1), 32'h0000_8001);
    wr(6'h00, 32'h0);
    wr(6'h10, 32'h0);
    check_enables("R3 zero set");

    // R4 clear, zero bits inert, whole-lane clear
    wr(6'h04, 32'h0);
    check_enables("R4 zero clear");
    wr(6'h04, 32'h0000_FF00);
    rd(6'h00, r); check("R4 lane clear", r, 32'hA5C3_0096);
    wr(6'h04, 32'h0100_0004);
    check_enables("R4 clear");

    // R7 dead lanes and dead set
    wr(6'h10, 32'hFFFF_FFFF);
    rd(6'h14, r); check("R7 dead lanes", r, 32'h0000_FFFF);
    wr(6'h20, 32'hFFFF_FFFF);
    rd(6'h20, r); check("R7 dead set read", r, 32'h0);
    rd(6'h30, r); check("R7 dead set read", r, 32'h0);
    check_enables("R7 dead set write");

    // R6 writes to +8 and +C ignored, +8 reads zero
    wr(6'h08, 32'hFFFF_FFFF);
    wr(6'h0C, 32'hFFFF_FFFF);
    wr(6'h1C, 32'hFFFF_FFFF);
    check_enables("R6 status write");
    rd(6'h08, r); check("R6 gap read", r, 32'h0);

    // R1 / R5 / R8 / R10 single source walk with all enabled
    wr(6'h00, 32'hFFFF_FFFF);
    check_enables("R5 readback");
    for (int n = 0; n < NS; n++) begin
      @(negedge clk);
      src = '0; src[n] = 1'b1; pgrp = GW'(n / 8);
      #1 if (n == 0) check("R1 registered delay", 32'(irq), 32'h0);
      @(negedge clk);
      check("R1 walk irq", 32'(irq), irq_of());
      check("R1 walk group bit", 32'(irq), 32'(1) << (n / 8));
      check("R8 walk pick", 32'(pcode), 32'(n));
      rd(AW'((n / 32) * 16 + 12), r);
      check("R6 walk status", r, word_of(src & m_en, n / 32));
      @(negedge clk);
      src = '0;
      @(negedge clk);
      check("R10 drop", 32'(irq), 32'h0);
      check("R8 empty", 32'(pcode), NOP);
    end

    // R8 / R1 exhaustive per-group sweep with mixed enables
    wr(6'h04, 32'h5A00_F00F);
    wr(6'h14, 32'h0000_3C81);
    check_enables("R4 mixed");
    for (int g = 0; g < NG; g++) begin
      for (int v = 0; v < 256; v++) begin
        @(negedge clk);
        src = '1;
        src[g*8 +: 8] = 8'(v);
        pgrp = GW'(g);
        @(negedge clk);
        check("R8 sweep pick", 32'(pcode), 32'(pick_of(g)));
        check("R1 sweep irq", 32'(irq), irq_of());
      end
      rd(AW'((g / 4) * 16 + 12), r);
      check("R6 sweep status", r, word_of(src & m_en, g / 4));
    end

    // R8 absent groups
    for (int g = NG; g < 8; g++) begin
      @(negedge clk);
      src = '1; pgrp = GW'(g);
      @(negedge clk);
      check("R8 absent group", 32'(pcode), NOP);
    end

    // R10 enable clear drops output
    wr(6'h04, 32'hFFFF_FFFF);
    wr(6'h14, 32'hFFFF_FFFF);
    @(negedge clk);
    check("R10 disabled", 32'(irq), 32'h0);
    summary();
  end
endmodule